// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a single-port synchronous memory of 36-bit words. Each word is split into four 9-bit byte lanes, and each lane holds 8 data bits and 1 parity bit. Every control and address input is registered on the rising clock edge. Read data is flow-through: it is driven straight from the array at the address registered on the most recent edge, and there is no output register stage. The output driver is modelled as a valid flag plus a data bus that reads zero whenever the driver would be high-impedance.

A transfer begins when either of two address strobes is low. The processor-side strobe has priority over the controller-side strobe. A cycle started by the processor strobe is always a read. After a transfer has started, a 2-bit counter steps through the low address bits while the advance input is low. The counter wraps inside the aligned four-word block. Holding advance high suspends the burst so that the same address repeats. Three chip enables qualify every strobe. A strobe seen while any enable is inactive deselects the memory and ends the burst.

Writes are selected by a global-write input, a byte-write-enable input and one select per lane. The array depth is set by a parameter.

Top module: `flow_burst_sram`

## Requirements
- R1: While reset is low and after it is released, the output is invalid (dataOutValid=0, dataOut=0) and no burst is active until a strobe arrives.
- R2: A strobe edge (procStrobeN or ctrlStrobeN low) with all enables active (chipEn1N=0, chipEn2=1, chipEn3N=0) loads addrIn into the address register. If the cycle is a read, the word at that address appears at dataOut in the clock cycle that follows the edge.
- R3: When procStrobeN is low, ctrlStrobeN has no effect in the same cycle, and the cycle is a read at addrIn.
- R4: A write takes place only in an enabled cycle that is either a ctrlStrobeN-started cycle (with procStrobeN high) or a burst continuation cycle, and only when the write inputs request one. dataIn is stored at that cycle's address on the same edge.
- R5: In a cycle started by procStrobeN, the write inputs are ignored, the cycle is a read, and the array is left unchanged.
- R6: In a live burst, a cycle with no strobe and advanceN high repeats the current address.
- R7: In a live burst, a cycle with no strobe and advanceN low adds one modulo 4 to address bits [1:0] and holds the upper bits. A burst started at low bits 2 therefore visits 2,3,0,1.
- R8: Lane decode: globalWriteN=0 writes all four lanes. Otherwise byteWriteEnN=1 means a read. With byteWriteEnN=0, lane i (bits [9i+8:9i]) is written when byteSelN[i]=0. If no lane is selected, the cycle is a read.
- R9: dataOutValid is high only in the cycle after a read edge and only while outEnN is low. outEnN acts combinationally. The output is invalid after a write edge.
- R10: A strobe with any enable inactive deselects the memory. The output becomes invalid, and advance cycles have no effect until the next enabled strobe.
- R11: A burst continuation cycle (no strobe) writes when the write inputs request it, and otherwise reads the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| addrIn | input | ADDR_W | Word address, loaded on an enabled strobe |
| procStrobeN | input | 1 | Processor-side address strobe, active low, has priority |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low; high suspends the burst |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| globalWriteN | input | 1 | Writes all lanes when low |
| byteWriteEnN | input | 1 | Qualifies the per-lane selects when low |
| byteSelN | input | 4 | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low, combinational |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| dataOut | output | 36 | Read data, zero when not driven |
| dataOutValid | output | 1 | High when the output would be driven |

## Verification
The bound checker watches, on every cycle, the rules that depend on a single edge or on one pair of adjacent edges: strobe priority, address capture, the suspend and wrap arithmetic of the counter, the all-lane write under global write, output gating by output enable, quiet output after a write or a deselect, and the frozen address after a deselect. Only the bench scenarios can show that data actually lands in the selected lanes and comes back unchanged later. The same holds for a write attempted under a processor strobe, which must leave the array untouched, and for a whole burst returning the wrapped sequence of stored words. The bench shows these by comparing against a reference memory model across directed bursts and a long run of random traffic.

// File: rtl/flow_burst_sram_pkg.sv
package flow_burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic             loadAddr;
    logic             stepAddr;
    logic             writeEn;
    logic [LANES-1:0] laneWe;
  } fbsStrobeT;
endpackage

// File: rtl/fbs_lane_bank.sv
module fbs_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
  end

  // flow-through: combinational read of the registered address
  assign rData = cells[rAddr];
endmodule

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import flow_burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             chipEn1N,
  input  logic             chipEn2,
  input  logic             chipEn3N,
  input  logic             globalWriteN,
  input  logic             byteWriteEnN,
  input  logic [LANES-1:0] byteSelN,
  output fbsStrobeT        strb,
  output logic             readLive,
  output logic             burstLive
);
  logic             enablesOk;
  logic             anyStrobe;
  logic             procWins;
  logic [LANES-1:0] laneReq;
  logic             wantWrite;
  logic             cycleGo;
  logic             doWrite;
  logic             nextLive;
  logic             nextRead;

  assign enablesOk = !chipEn1N && chipEn2 && !chipEn3N;
  assign anyStrobe = !procStrobeN || !ctrlStrobeN;
  assign procWins  = !procStrobeN;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_req
    assign laneReq[i] = !globalWriteN || (!byteWriteEnN && !byteSelN[i]);
  end

  assign wantWrite = |laneReq;

  always_comb begin
    cycleGo       = (anyStrobe && enablesOk) || (!anyStrobe && burstLive);
    doWrite       = cycleGo && !procWins && wantWrite;
    strb.loadAddr = anyStrobe && enablesOk;
    strb.stepAddr = !anyStrobe && burstLive && !advanceN;
    strb.writeEn  = doWrite;
    strb.laneWe   = doWrite ? laneReq : '0;
    nextLive      = anyStrobe ? enablesOk : burstLive;
    nextRead      = cycleGo && !doWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLive <= 1'b0;
      readLive  <= 1'b0;
    end else begin
      burstLive <= nextLive;
      readLive  <= nextRead;
    end
  end
endmodule

// File: rtl/fbs_datapath.sv
module fbs_datapath
  import flow_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbsStrobeT         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [WORD_W-1:0] dataIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [WORD_W-1:0] rdWord
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] nextAddr;
  logic [CNT_W-1:0]  burstCnt;
  logic [UPPER_W-1:0] upperAddr;

  assign burstCnt  = curAddr[CNT_W-1:0];
  assign upperAddr = curAddr[ADDR_W-1:CNT_W];

  always_comb begin
    if (strb.loadAddr)      nextAddr = addrIn;
    else if (strb.stepAddr) nextAddr = {upperAddr, burstCnt + CNT_W'(1)};
    else                    nextAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curAddr <= '0;
    else       curAddr <= nextAddr;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    fbs_lane_bank #(
      .ADDR_W(ADDR_W),
      .DATA_W(LANE_W)
    ) u_bank (
      .clk  (clk),
      .we   (strb.writeEn && strb.laneWe[i]),
      .wAddr(nextAddr),
      .wData(dataIn[i*LANE_W +: LANE_W]),
      .rAddr(curAddr),
      .rData(rdWord[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/flow_burst_sram.sv
module flow_burst_sram
  import flow_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              globalWriteN,
  input  logic              byteWriteEnN,
  input  logic [3:0]        byteSelN,
  input  logic              outEnN,
  input  logic [35:0]       dataIn,
  output logic [35:0]       dataOut,
  output logic              dataOutValid
);
  fbsStrobeT         strb;
  logic              readLive;
  logic              burstLive;
  logic [ADDR_W-1:0] curAddr;
  logic [WORD_W-1:0] rdWord;

  fbs_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .chipEn1N    (chipEn1N),
    .chipEn2     (chipEn2),
    .chipEn3N    (chipEn3N),
    .globalWriteN(globalWriteN),
    .byteWriteEnN(byteWriteEnN),
    .byteSelN    (byteSelN),
    .strb        (strb),
    .readLive    (readLive),
    .burstLive   (burstLive)
  );

  fbs_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .curAddr(curAddr),
    .rdWord (rdWord)
  );

  assign dataOutValid = readLive && !outEnN;
  assign dataOut      = dataOutValid ? rdWord : '0;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker
  import flow_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              chipEn1N,
  input logic              chipEn2,
  input logic              chipEn3N,
  input logic              globalWriteN,
  input logic              outEnN,
  input logic              dataOutValid,
  input logic [ADDR_W-1:0] curAddr,
  input fbsStrobeT         strb,
  input logic              burstLive
);
  logic enOk;
  logic strobeLow;
  assign enOk      = !chipEn1N && chipEn2 && !chipEn3N;
  assign strobeLow = !procStrobeN || !ctrlStrobeN;

  AST_PROC_READS: assert property (@(posedge clk) disable iff (!rstN)
    !procStrobeN |-> !strb.writeEn); // R5
  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ctrlStrobeN && enOk) |=> !outEnN -> dataOutValid); // R3
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobeLow && enOk) |=> curAddr == $past(addrIn)); // R2
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeLow && advanceN) |=> $stable(curAddr)); // R6
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeLow && !advanceN && burstLive) |=>
      (curAddr[1:0] == $past(curAddr[1:0]) + 2'd1) &&
      (curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]))); // R7
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!globalWriteN && procStrobeN && !ctrlStrobeN && enOk) |-> strb.laneWe == 4'hF); // R8
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOutValid); // R9
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |=> !dataOutValid); // R9
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (strobeLow && !enOk) |=> !dataOutValid && !burstLive); // R10
  AST_DESEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!burstLive && !strobeLow) |=> $stable(curAddr)); // R10
endmodule

bind flow_burst_sram fbs_checker #(.ADDR_W(ADDR_W)) u_fbs_checker (
  .clk         (clk),
  .rstN        (rstN),
  .addrIn      (addrIn),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .advanceN    (advanceN),
  .chipEn1N    (chipEn1N),
  .chipEn2     (chipEn2),
  .chipEn3N    (chipEn3N),
  .globalWriteN(globalWriteN),
  .outEnN      (outEnN),
  .dataOutValid(dataOutValid),
  .curAddr     (curAddr),
  .strb        (strb),
  .burstLive   (burstLive)
);

// File: tb/flow_burst_sram_bench.sv
`timescale 1ns/1ps
module flow_burst_sram_bench;
  localparam int A     = 10;
  localparam int DEPTH = 1 << A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [A-1:0]  addrIn = '0;
  logic          pN = 1'b1, cN = 1'b1, advN = 1'b1;
  logic          ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic          gwN = 1'b1, bweN = 1'b1;
  logic [3:0]    bsN = 4'hF;
  logic          oeN = 1'b0;
  logic [35:0]   dIn = '0;
  logic [35:0]   dOut;
  logic          dValid;

  int testCount = 0;
  int failCount = 0;

  logic [35:0]  model [DEPTH];
  logic         mLive = 1'b0;
  logic         mRead = 1'b0;
  logic [A-1:0] mAddr = '0;

  always #10 clk = ~clk;

  flow_burst_sram #(.ADDR_W(A)) u_flow_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(pN), .ctrlStrobeN(cN), .advanceN(advN),
    .chipEn1N(ce1N), .chipEn2(ce2), .chipEn3N(ce3N),
    .globalWriteN(gwN), .byteWriteEnN(bweN), .byteSelN(bsN),
    .outEnN(oeN), .dataIn(dIn), .dataOut(dOut), .dataOutValid(dValid)
  );

  function automatic logic [35:0] pattern(input int a);
    return {4'hA, 32'(a * 32'h9E37_79B1 + 32'h1357)};
  endfunction

  task automatic modelEdge();
    logic ce, strobe, go, wr;
    logic [3:0] lanes;
    logic [A-1:0] a;
    ce = !ce1N && ce2 && !ce3N;
    strobe = !pN || !cN;
    for (int i = 0; i < 4; i++) lanes[i] = !gwN || (!bweN && !bsN[i]);
    go = 1'b0;
    a = mAddr;
    if (strobe) begin
      mLive = ce;
      if (ce) begin go = 1'b1; a = addrIn; end
    end else if (mLive) begin
      go = 1'b1;
      if (!advN) a = {mAddr[A-1:2], mAddr[1:0] + 2'd1};
    end
    wr = go && pN && (|lanes);
    if (go) mAddr = a;
    if (wr)
      for (int i = 0; i < 4; i++)
        if (lanes[i]) model[a][i*9 +: 9] = dIn[i*9 +: 9];
    mRead = go && !wr;
  endtask

  task automatic check(input string tag);
    logic expV;
    logic [35:0] expD;
    expV = mRead && !oeN;
    expD = expV ? model[mAddr] : 36'h0;
    testCount++;
    if (dValid !== expV || dOut !== expD) begin
      failCount++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, dValid, dOut, expV, expD);
    end
  endtask

  task automatic step(input string tag);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    pN = 1'b1; cN = 1'b1; advN = 1'b1;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    gwN = 1'b1; bweN = 1'b1; bsN = 4'hF; oeN = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failCount++;
    $display("FAIL watchdog: valid=%0b data=%h expected run completion", dValid, dOut);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 36'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    step("R1 after reset idle");
    advN = 1'b0;
    step("R1 advance without burst");
    idle();

    // fill every word with single controller-strobe writes
    for (int i = 0; i < DEPTH; i++) begin
      cN = 1'b0; gwN = 1'b0; addrIn = A'(i); dIn = pattern(i);
      step("R4 fill write quiet");
    end
    idle();

    // R2 read flow-through
    pN = 1'b0; addrIn = 10'd5;
    step("R2 strobe read");
    idle();

    // R5 processor strobe ignores write inputs
    pN = 1'b0; gwN = 1'b0; addrIn = 10'd9; dIn = 36'h0_DEAD_BEEF;
    step("R5 proc strobe reads");
    idle(); pN = 1'b0; addrIn = 10'd9;
    step("R5 array unchanged");

    // R3 controller strobe ignored under processor strobe
    idle(); pN = 1'b0; cN = 1'b0; gwN = 1'b0; addrIn = 10'd17; dIn = 36'h1_1111_1111;
    step("R3 ctrl ignored");
    idle(); pN = 1'b0; addrIn = 10'd17;
    step("R3 word intact");

    // R8 lane writes
    idle(); cN = 1'b0; bweN = 1'b0; bsN = 4'b1010; addrIn = 10'd33; dIn = 36'hF_FFFF_FFFF;
    step("R8 lanes 0 and 2");
    idle(); cN = 1'b0; bweN = 1'b0; bsN = 4'hF; addrIn = 10'd33;
    step("R8 no select reads");
    idle(); cN = 1'b0; bweN = 1'b1; bsN = 4'h0; addrIn = 10'd34; dIn = 36'h0;
    step("R8 byte enable high reads");

    // R4 disabled write attempt, then readback
    idle(); ce3N = 1'b1; cN = 1'b0; gwN = 1'b0; addrIn = 10'd40; dIn = 36'h0;
    step("R4 disabled no write");
    idle(); pN = 1'b0; addrIn = 10'd40;
    step("R4 readback after disabled");

    // R7 wrap from low bits 2
    idle(); pN = 1'b0; addrIn = 10'd66;
    step("R7 burst start");
    idle(); advN = 1'b0;
    for (int k = 0; k < 4; k++) step("R7 wrap step");
    // R6 suspend
    idle();
    for (int k = 0; k < 3; k++) step("R6 suspend repeat");

    // R11 continuation writes then reads
    idle(); cN = 1'b0; gwN = 1'b0; addrIn = 10'd100; dIn = 36'h2_2222_2222;
    step("R11 burst write start");
    idle(); advN = 1'b0; gwN = 1'b0; dIn = 36'h3_3333_3333;
    step("R11 continuation write");
    idle(); advN = 1'b0;
    for (int k = 0; k < 4; k++) step("R11 continuation read");

    // R9 output enable
    idle(); pN = 1'b0; addrIn = 10'd7; oeN = 1'b1;
    step("R9 oe high hides read");
    idle(); oeN = 1'b0;
    step("R9 oe low shows read");

    // R10 deselect ends burst
    idle(); pN = 1'b0; ce2 = 1'b0; addrIn = 10'd200;
    step("R10 deselect");
    idle(); advN = 1'b0;
    for (int k = 0; k < 3; k++) step("R10 advance ignored");
    idle(); pN = 1'b0; addrIn = 10'd200;
    step("R10 reselect read");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      pN   = ($urandom % 100) >= 15;
      cN   = ($urandom % 100) >= 20;
      advN = $urandom % 2;
      ce1N = ($urandom % 100) < 5;
      ce2  = ($urandom % 100) >= 5;
      ce3N = ($urandom % 100) < 5;
      gwN  = ($urandom % 100) >= 10;
      bweN = ($urandom % 100) >= 40;
      bsN  = 4'($urandom);
      oeN  = ($urandom % 100) < 10;
      addrIn = A'($urandom);
      dIn  = {4'($urandom), 32'($urandom)};
      step("R11 random traffic");
    end
    idle();
    finishRun();
  end
endmodule